// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a running time value in nanoseconds for precision time stamping. On every reference clock cycle while it runs, it adds a programmable step to the count. Once per programmable trim interval it adds a second, separately programmed step instead. Software uses this to pull the average rate up or down in small amounts without changing the reference clock.

The count can wrap at a programmable limit. A limit of 2^31 turns it into a 31-bit counter. Each wrap raises a one-cycle strobe that downstream compare logic can use. Software controls the block through a plain word-addressed write port and a combinational read port. Through that port it can start and stop the count, clear it to zero, load any value, and freeze a snapshot that it reads back later at leisure.

Register map (word addresses): 0 control, 1 time (a read returns the snapshot, a write loads the count), 2 wrap limit, 3 step pair, 4 trim interval.

Top module: `ns_timer`

## Requirements
- R1: After reset the count is 0, the strobe is low, and every register reads back 0.
- R2: While control bit 0 (run) is 1, the count advances by the normal step in step bits 6:0 on each clock. While run is 0 and nothing is written, the count holds its value.
- R3: When the trim interval P is nonzero, the trim step in step bits 14:8 replaces the normal step on every (P+1)-th running cycle, counted from a clear. When P is 0 the trim step is never used.
- R4: When control bit 1 (wrap enable) is 1 and count plus step reaches or exceeds the wrap limit, the count becomes count plus step minus the limit. When wrap enable is 0 the count runs modulo 2^32.
- R5: The strobe is high for exactly the cycle in which the wrapped value is first visible, and only when control bit 2 (event enable) is also 1. It stays low when event enable is 0.
- R6: Writing control with bit 3 (clear) set forces the count and the trim position to zero in the next cycle. Bit 3 always reads back as 0.
- R7: Writing control with bit 4 (snapshot) set latches the count of that cycle. Reading address 1 returns that snapshot, unchanged, until the next snapshot. Bit 4 always reads back as 0.
- R8: A write to address 1 loads the count with the written value, and counting continues from there.
- R9: The wrap limit, step pair and trim interval read back as written, and the control register reads back bits 2:0.
- R10: With the wrap limit at 0x8000_0000, a count that crosses 2^31 restarts near zero and raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for both read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| time_ns | output | CNT_W | Live nanosecond count |
| period_evt | output | 1 | One-cycle strobe on a wrap |

## Verification
The hardest case to reach is the full 31-bit wrap. Counting there from zero takes more than two billion nanoseconds, so the stimulus loads a value a few steps below 2^31 and then lets a single step cross the limit. Placing the trim step on exact cycles is the other subtle point. The stimulus sweeps every trim interval from 0 to 4 against two step pairs, one of them with a zero trim step. After each clear it compares the count cycle by cycle with a closed-form sum.

// File: rtl/ns_timer.sv
`timescale 1ns/1ps
module ns_timer #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [CNT_W-1:0]  time_ns,
  output logic              period_evt
);
  localparam logic [ADDR_W-1:0] A_CTRL = 0;
  localparam logic [ADDR_W-1:0] A_TIME = 1;
  localparam logic [ADDR_W-1:0] A_WRAP = 2;
  localparam logic [ADDR_W-1:0] A_STEP = 3;
  localparam logic [ADDR_W-1:0] A_TRIM = 4;
  localparam int TRIM_LSB = 8;

  logic              run, wrap_en, evt_en;
  logic [CNT_W-1:0]  cnt, snap, wrap_at, trim_per, trim_cnt;
  logic [STEP_W-1:0] step, tstep;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire time_wr = wr_en && addr == A_TIME;
  wire do_clear = ctrl_wr && wdata[3];
  wire do_snap  = ctrl_wr && wdata[4];

  wire trim_on  = trim_per != '0;
  wire trim_hit = trim_on && trim_cnt >= trim_per;
  wire [STEP_W-1:0] inc = trim_hit ? tstep : step;
  wire [CNT_W:0] sum = {1'b0, cnt} + {{(CNT_W+1-STEP_W){1'b0}}, inc};
  wire crossing = wrap_en && sum >= {1'b0, wrap_at};
  wire [CNT_W-1:0] wrapped = sum[CNT_W-1:0] - wrap_at;
  wire [CNT_W-1:0] nxt = crossing ? wrapped : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; wrap_en <= 1'b0; evt_en <= 1'b0;
      cnt <= '0; snap <= '0; wrap_at <= '0; trim_per <= '0; trim_cnt <= '0;
      step <= '0; tstep <= '0; period_evt <= 1'b0;
    end else begin
      period_evt <= 1'b0;
      if (ctrl_wr) begin
        run <= wdata[0]; wrap_en <= wdata[1]; evt_en <= wdata[2];
      end
      if (do_snap) snap <= cnt;
      if (wr_en && addr == A_WRAP) wrap_at <= wdata;
      if (wr_en && addr == A_TRIM) trim_per <= wdata;
      if (wr_en && addr == A_STEP) begin
        step  <= wdata[STEP_W-1:0];
        tstep <= wdata[TRIM_LSB +: STEP_W];
      end
      if (do_clear) begin
        cnt <= '0; trim_cnt <= '0;
      end else if (time_wr) begin
        cnt <= wdata;
      end else if (run) begin
        cnt <= nxt;
        trim_cnt <= (trim_hit || !trim_on) ? '0 : trim_cnt + 1'b1;
        period_evt <= crossing && evt_en;
      end
    end
  end

  logic [CNT_W-1:0] step_rd;
  always_comb begin
    step_rd = '0;
    step_rd[STEP_W-1:0] = step;
    step_rd[TRIM_LSB +: STEP_W] = tstep;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(CNT_W-3){1'b0}}, evt_en, wrap_en, run};
      A_TIME:  rdata = snap;
      A_WRAP:  rdata = wrap_at;
      A_STEP:  rdata = step_rd;
      A_TRIM:  rdata = trim_per;
      default: rdata = '0;
    endcase
  end

  assign time_ns = cnt;
endmodule

// File: rtl/ns_timer_chk.sv
`timescale 1ns/1ps
module ns_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  time_ns,
  input logic              period_evt,
  input logic              run,
  input logic              wrap_en,
  input logic              evt_en,
  input logic [CNT_W-1:0]  snap
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> time_ns == $past(time_ns));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 0 && wdata[3]) |=> time_ns == '0);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 1) |=> time_ns == $past(wdata));

  assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 0 && wdata[4]) |=> snap == $past(time_ns));

  assert_evt_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |-> $past(wrap_en && evt_en && run));
endmodule

bind ns_timer ns_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .time_ns(time_ns), .period_evt(period_evt), .run(run),
  .wrap_en(wrap_en), .evt_en(evt_en), .snap(snap)
);

// File: tb/tb_ns_timer.sv
`timescale 1ns/1ps
module tb_ns_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, time_ns;
  logic        period_evt;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  ns_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .time_ns(time_ns), .period_evt(period_evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, snapv;
    repeat (3) @(negedge clk);
    chk("R1 count", time_ns, 0);
    chk("R1 strobe", {31'b0, period_evt}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v); chk("R1 reg", v, 0);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 sweep of step pairs and trim intervals
    for (int sp = 0; sp < 2; sp++) begin
      for (int p = 0; p < 5; p++) begin
        int s, t;
        s = (sp == 0) ? 1 : 6;
        t = (sp == 0) ? 9 : 0;
        wr(3, (t << 8) | s);
        wr(4, p);
        wr(0, 32'h9);
        chk("R6 cleared", time_ns, 0);
        rd(3, v); chk("R9 step pair", v, (t << 8) | s);
        rd(4, v); chk("R9 trim", v, p);
        rd(0, v); chk("R6 clear reads 0", v, 1);
        for (int k = 1; k <= 12; k++) begin
          int e;
          @(negedge clk);
          e = k * s + ((p == 0) ? 0 : (k / (p + 1)) * (t - s));
          chk((p == 0) ? "R2 plain step" : "R3 trim step", time_ns, e);
        end
      end
    end

    // R2 hold with run off
    wr(0, 0);
    v = time_ns;
    repeat (5) @(negedge clk);
    chk("R2 hold", time_ns, v);

    // R4 R5 wrap with strobe
    wr(3, 7); wr(4, 0); wr(2, 100);
    rd(2, v); chk("R9 wrap limit", v, 100);
    wr(0, 32'h0F);
    rd(0, v); chk("R9 ctrl", v, 7);
    for (int k = 1; k <= 40; k++) begin
      int sm;
      @(negedge clk);
      sm = 7 * k;
      chk("R4 wrap value", time_ns, sm % 100);
      chk("R5 strobe", {31'b0, period_evt}, ((sm / 100) != ((sm - 7) / 100)) ? 1 : 0);
    end

    // R5 strobe disabled
    wr(0, 32'h0B);
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      chk("R4 wrap value", time_ns, (7 * k) % 100);
      chk("R5 no strobe", {31'b0, period_evt}, 0);
    end

    // R4 wrap disabled passes the limit
    wr(2, 20); wr(0, 32'h09);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R4 no wrap", time_ns, 7 * k);
    end

    // R8 load
    wr(1, 1234);
    chk("R8 load", time_ns, 1234);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R8 continue", time_ns, 1234 + 7 * k);
    end

    // R7 snapshot
    snapv = time_ns;
    wr(0, 32'h11);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R7 snapshot", v, snapv);
    rd(0, v); chk("R7 snap reads 0", v, 1);
    chk("R7 count runs on", time_ns, snapv + 7 * 4);
    repeat (2) @(negedge clk);
    rd(1, v); chk("R7 snapshot stable", v, snapv);

    // R10 31-bit wrap
    wr(3, 5); wr(2, 32'h8000_0000); wr(0, 32'h0F);
    wr(1, 32'h7FFF_FFFC);
    chk("R10 loaded", time_ns, 32'h7FFF_FFFC);
    @(negedge clk);
    chk("R10 wrapped", time_ns, 1);
    chk("R10 strobe", {31'b0, period_evt}, 1);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'b0, period_evt}, 0);

    // R4 free run modulo 2^32
    wr(0, 32'h01);
    wr(1, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R4 modulo", time_ns, 3);
    chk("R5 no strobe free run", {31'b0, period_evt}, 0);

    finish_run();
  end
endmodule